// File: doc/BRIEF.md
# Adaptive Measurement Window Controller

This block decides how long each traffic measurement window lasts and marks the end of each window. It runs a self-tuning loop. When a window expires, it samples the average network latency for that window. It compares the sample with the latency and length of the window before. From the two it forms a gradient. It then moves the next window's length against that gradient, scaled by a programmable fixed-point step. The new length is held between programmable bounds. A down-counter then times the new window out.

A latency monitor elsewhere produces the latency value. It must hold that value steady on `lat_in` during the cycle in which `win_end` is high. A reconfiguration controller uses `win_end` as its trigger. It reads `win_len` to learn how long the coming window will be. The division in the update is done bit-serially, and the next window starts only after the quotient is complete.

Top module: `adaptive_window_ctrl`

## Requirements
- R1: While `rst_n` is low, `win_len` and `win_end` are 0. The first window after reset has length clamp(`init_len`) (see R8). Its `win_end` pulse comes exactly that many cycles after the first rising clock edge at which `rst_n` is high.
- R2: If a window end does not start a division, the next window begins on the following cycle. Its pulse then comes exactly L cycles after the previous pulse, where L is the new `win_len`.
- R3: `win_end` is never high on two consecutive cycles. Every window length is at least 2.
- R4: The first window after reset has no earlier window, so no gradient is formed for it. The second window gets length clamp(first length + PROBE), where PROBE defaults to 4.
- R5: If the window that just ended has the same length as the one before it, the gradient is zero. The length stays unchanged and no division is started.
- R6: Otherwise, let dLat be current latency minus previous latency and dLen be current length minus previous length. Let q = floor(`step` × |dLat| / |dLen|) and a = floor(q / 256), since `step` is unsigned with 8 fractional bits. If dLat and dLen have the same sign, the next length is clamp(current − a). If they have opposite signs, it is clamp(current + a).
- R7: An update under R6 takes a bit-serial division. The next pulse comes exactly NUM_W + 1 + L cycles after the previous one, where NUM_W = STEP_W + LAT_W + 1 (21 by default). `win_len` keeps its old value until the new length is applied.
- R8: clamp(v) returns lo if v < lo, returns `max_len` if v > `max_len`, and otherwise returns v. Here lo is `min_len`, raised to 2 when `min_len` is below 2. The bounds are assumed to satisfy lo ≤ `max_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_len | input | LEN_W | Length of the first window after reset |
| min_len | input | LEN_W | Lower length bound (at least 2 is enforced) |
| max_len | input | LEN_W | Upper length bound |
| step | input | STEP_W | Descent step, unsigned, 8 fractional bits |
| lat_in | input | LAT_W | Average latency of the window now ending, sampled with `win_end` |
| win_len | output | LEN_W | Length of the current window |
| win_end | output | 1 | One-cycle pulse on the last cycle of a window |

## Verification
Each window's length and each gap between pulses is a direct, checked consequence of the whole internal state. An error in the stored previous latency or length, the quotient, the sign, or the down-counter therefore shows up as a wrong `win_len` or a mistimed `win_end` at the very next pulse. An error in the divider's step count shifts the next pulse by the same number of cycles. Several latency profiles are swept across bound, step and initial-length settings. These include convex, monotonic, constant and scrambled profiles. Together they drive every update path: probe, equal-length hold, descent, and clamping at both ends.

// File: rtl/adaptive_window_ctrl.sv
module adaptive_window_ctrl #(
  parameter int LEN_W  = 10,
  parameter int LAT_W  = 10,
  parameter int STEP_W = 10,
  parameter int FRAC   = 8,
  parameter int PROBE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  init_len,
  input  logic [LEN_W-1:0]  min_len,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [STEP_W-1:0] step,
  input  logic [LAT_W-1:0]  lat_in,
  output logic [LEN_W-1:0]  win_len,
  output logic              win_end
);
  localparam int NUM_W = STEP_W + LAT_W + 1;
  localparam int SW    = NUM_W + LEN_W + 2;
  localparam int BC_W  = $clog2(NUM_W + 1);

  typedef enum logic [1:0] {S_LOAD, S_COUNT, S_DIV, S_APPLY} st_t;

  st_t               state;
  logic [LEN_W-1:0]  cur_len, prev_len, cnt;
  logic [LAT_W-1:0]  prev_lat;
  logic              have_prev, neg;
  logic [NUM_W-1:0]  dvd, quo;
  logic [LEN_W:0]    dvs, rem;
  logic [BC_W-1:0]   bitc;

  function automatic logic [LEN_W-1:0] clampv(input logic signed [SW-1:0] v,
                                              input logic [LEN_W-1:0] lo,
                                              input logic [LEN_W-1:0] hi);
    logic signed [SW-1:0] lo_s, hi_s;
    lo_s = $signed({{(SW-LEN_W){1'b0}}, lo});
    hi_s = $signed({{(SW-LEN_W){1'b0}}, hi});
    if (v < lo_s)      return lo;
    else if (v > hi_s) return hi;
    else               return v[LEN_W-1:0];
  endfunction

  logic [LEN_W-1:0] lo_b;
  assign lo_b = (min_len < LEN_W'(2)) ? LEN_W'(2) : min_len;

  assign win_len = cur_len;
  assign win_end = (state == S_COUNT) && (cnt == '0);

  logic signed [LAT_W:0] dlat;
  logic signed [LEN_W:0] dlen;
  logic [LAT_W:0]        lat_abs;
  logic [LEN_W:0]        len_abs;
  logic [NUM_W-1:0]      prod;
  assign dlat    = $signed({1'b0, lat_in})  - $signed({1'b0, prev_lat});
  assign dlen    = $signed({1'b0, cur_len}) - $signed({1'b0, prev_len});
  assign lat_abs = dlat[LAT_W] ? $unsigned(-dlat) : $unsigned(dlat);
  assign len_abs = dlen[LEN_W] ? $unsigned(-dlen) : $unsigned(dlen);
  assign prod    = NUM_W'(step) * NUM_W'(lat_abs);

  logic [LEN_W+1:0] shifted;
  logic             fits;
  logic [LEN_W:0]   rem_nx;
  assign shifted = {rem, dvd[NUM_W-1]};
  assign fits    = shifted >= {1'b0, dvs};
  assign rem_nx  = fits ? (LEN_W+1)'(shifted - {1'b0, dvs}) : shifted[LEN_W:0];

  logic [NUM_W-1:0]     adj;
  logic signed [SW-1:0] cur_s, adj_s;
  logic [LEN_W-1:0]     init_c, probe_c, apply_c;
  assign adj     = quo >> FRAC;
  assign cur_s   = $signed({{(SW-LEN_W){1'b0}}, cur_len});
  assign adj_s   = $signed({{(SW-NUM_W){1'b0}}, adj});
  assign init_c  = clampv($signed({{(SW-LEN_W){1'b0}}, init_len}), lo_b, max_len);
  assign probe_c = clampv(cur_s + SW'(PROBE), lo_b, max_len);
  assign apply_c = clampv(neg ? (cur_s + adj_s) : (cur_s - adj_s), lo_b, max_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_LOAD;
      cur_len   <= '0;
      prev_len  <= '0;
      prev_lat  <= '0;
      cnt       <= '0;
      have_prev <= 1'b0;
      neg       <= 1'b0;
      dvd       <= '0;
      dvs       <= '0;
      rem       <= '0;
      quo       <= '0;
      bitc      <= '0;
    end else begin
      case (state)
        S_LOAD: begin
          cur_len <= init_c;
          cnt     <= init_c - 1'b1;
          state   <= S_COUNT;
        end
        S_COUNT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            prev_lat  <= lat_in;
            prev_len  <= cur_len;
            have_prev <= 1'b1;
            if (!have_prev) begin
              cur_len <= probe_c;
              cnt     <= probe_c - 1'b1;
            end else if (dlen == '0) begin
              cnt <= cur_len - 1'b1;
            end else begin
              neg   <= dlat[LAT_W] ^ dlen[LEN_W];
              dvd   <= prod;
              dvs   <= len_abs;
              rem   <= '0;
              quo   <= '0;
              bitc  <= BC_W'(NUM_W - 1);
              state <= S_DIV;
            end
          end
        end
        S_DIV: begin
          dvd <= dvd << 1;
          rem <= rem_nx;
          quo <= {quo[NUM_W-2:0], fits};
          if (bitc == '0) state <= S_APPLY;
          else            bitc  <= bitc - 1'b1;
        end
        default: begin
          cur_len <= apply_c;
          cnt     <= apply_c - 1'b1;
          state   <= S_COUNT;
        end
      endcase
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);

  assert_len_in_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COUNT) |-> (cur_len >= lo_b && cur_len <= max_len));

  assert_hold_during_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV) |=> $stable(win_len) && !win_end);

  assert_flat_keeps_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && have_prev && cur_len == prev_len) |=> (state == S_COUNT && win_len == $past(win_len)));

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COUNT && cnt != '0) |=> (state == S_COUNT && cnt == $past(cnt) - 1'b1));

  assert_probe_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !have_prev) |=> (have_prev && state == S_COUNT));
endmodule

// File: tb/adaptive_window_ctrl_tb.sv
module adaptive_window_ctrl_tb;
  localparam int LEN_W = 10, LAT_W = 10, STEP_W = 10, PROBE = 4;
  localparam int NUM_W = STEP_W + LAT_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LEN_W-1:0] init_len = '0, min_len = '0, max_len = '0;
  logic [STEP_W-1:0] step = '0;
  logic [LAT_W-1:0] lat_in = '0;
  logic [LEN_W-1:0] win_len;
  logic win_end;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adaptive_window_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .init_len(init_len), .min_len(min_len),
    .max_len(max_len), .step(step), .lat_in(lat_in),
    .win_len(win_len), .win_end(win_end));

  function automatic int latf(int pat, int len, int k);
    int v;
    case (pat)
      0: begin v = (len - 150) * (len - 150) / 32 + 50; if (v > 1023) v = 1023; end
      1: begin v = 1023 - 2 * len; if (v < 0) v = 0; end
      2: v = 500;
      default: v = (len * 37 + k * 91) % 1024;
    endcase
    return v;
  endfunction

  function automatic int clampm(int v, int mn, int mx);
    int lo;
    lo = (mn < 2) ? 2 : mn;
    if (v < lo) return lo;
    if (v > mx) return mx;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(int i_len, int mn, int mx, int stp, int pat, int nwin);
    int cur, prev_len, prev_lat, have, widx, cyc, last, gap, lat;
    int dl, dn, q, a, v;
    bit prev_end;
    string gtag, ltag;
    rst_n = 1'b0;
    init_len = LEN_W'(i_len); min_len = LEN_W'(mn); max_len = LEN_W'(mx);
    step = STEP_W'(stp);
    repeat (3) @(negedge clk);
    check("R1 reset win_len", int'(win_len), 0);
    check("R1 reset win_end", int'(win_end), 0);
    cur = clampm(i_len, mn, mx);
    have = 0; prev_len = 0; prev_lat = 0; widx = 0; cyc = 0; last = 0;
    gap = cur; gtag = "R1 first gap"; ltag = "R1 first len";
    prev_end = 1'b0;
    lat_in = LAT_W'(latf(pat, cur, 0));
    rst_n = 1'b1;
    while (widx < nwin && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (win_end && prev_end) check("R3 back-to-back pulse", 1, 0);
      prev_end = win_end;
      if (win_end) begin
        check(ltag, int'(win_len), cur);
        check(gtag, cyc - last, gap);
        check("R3 min length", int'(win_len >= 2), 1);
        lat = latf(pat, int'(win_len), widx);
        if (have == 0) begin
          v = clampm(cur + PROBE, mn, mx);
          gap = v; gtag = "R2 gap after probe"; ltag = "R4 probe len";
        end else if (cur == prev_len) begin
          v = cur;
          gap = v; gtag = "R2 gap after hold"; ltag = "R5 held len";
        end else begin
          dl = lat - prev_lat; dn = cur - prev_len;
          q = (stp * (dl < 0 ? -dl : dl)) / (dn < 0 ? -dn : dn);
          a = q / 256;
          v = ((dl < 0) != (dn < 0)) ? cur + a : cur - a;
          ltag = (clampm(v, mn, mx) != v) ? "R8 clamped len" : "R6 descent len";
          v = clampm(v, mn, mx);
          gap = NUM_W + 1 + v; gtag = "R7 gap after divide";
        end
        prev_lat = lat; prev_len = cur; have = 1; cur = v;
        last = cyc; widx++;
      end
      lat_in = LAT_W'(latf(pat, int'(win_len), widx));
    end
    check("R2 windows completed", widx, nwin);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run_cfg(100, 20, 300, 256, 0, 12);
    run_cfg(200, 10, 400, 64, 0, 12);
    run_cfg(50, 0, 100, 1023, 1, 12);
    run_cfg(30, 1, 60, 512, 3, 14);
    run_cfg(80, 40, 120, 0, 0, 8);
    run_cfg(500, 20, 300, 300, 0, 6);
    run_cfg(3, 0, 50, 1023, 3, 16);
    run_cfg(120, 10, 250, 700, 2, 8);
    run_cfg(60, 0, 200, 900, 0, 14);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule